// File: doc/BRIEF.md
# Chainable result register FIFO

This block holds a bank of conversion result registers. Neighbouring registers can be linked into first-in first-out buffers by a per-register link bit in each register's control word. The links are decoded at run time, so one bank can hold several independent buffers of different depths next to single, unlinked registers. Inside a linked group, the register with the highest index takes in new results and the register with the lowest index is the one software reads. Every register in between only passes data toward the reader.

A finished result arrives on `res_valid_i` together with the index of a register in the target group and the result value. Accumulation, if any, happens upstream, so a pulse here always means a final value. The block puts the result into the lowest free register of the group. A clearing read of the group's lowest register moves every entry down by one. When a group is full, the top register either takes the overwrite or, if its hold-until-read bit is set, refuses the result by dropping `res_ready_o` until a clearing read frees a register.

Top module: `res_chain_fifo`

## Requirements
- R1: Register x is linked to register x+1 when bit 5 of the control word of x is set. A group spans the registers joined by links. Its highest index is the input stage and its lowest index is the output stage. The top register of the bank is always an input stage. A result sent to any member of a group is handled by that group.
- R2: Control word fields: bits 1:0 are the accumulation reload, bit 5 is the link, bit 6 is hold-until-read. `cfg_err_o[x]` is 1 exactly when register x is not an input stage and has bit 6 set or a nonzero reload.
- R3: After reset all valid flags and `full_o` are 0, and `res_ready_o` is 1.
- R4: An accepted result is written into the lowest-indexed empty register of its group, and that register's valid flag is set.
- R5: A clearing read (`rd_take_i`) of an output stage moves each register of the group one place toward the output. The input stage becomes empty, and other groups are unaffected.
- R6: A clearing read whose `rd_sel_i` is an input-only or intermediate stage changes no state.
- R7: When a group is full and its input stage lacks bit 6, a new result overwrites the input stage, the other stages keep their data, and `res_ready_o` stays 1.
- R8: When a group is full and its input stage has bit 6 set, `res_ready_o` is 0 and the result is not stored.
- R9: A clearing read and a new result in the same cycle: the result goes into the lowest empty register after the shift, and a read that frees a register raises `res_ready_o` in that cycle.
- R10: `full_o[x]` is 1 exactly when x is an input stage and every register of its group is valid.
- R11: `rd_data_o` shows the contents of register `rd_sel_i` at all times. Reading without `rd_take_i` changes nothing.
- R12: A link bit wrongly set on an input stage merges its group with the one above it, so results written to the upper group appear at the lower group's output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | NREG*16 | Control word per register |
| res_valid_i | input | 1 | Final result available |
| res_sel_i | input | log2(NREG) | Register the result is aimed at |
| res_data_i | input | DW | Result value |
| res_ready_o | output | 1 | Result can be taken this cycle |
| rd_sel_i | input | log2(NREG) | Register being read |
| rd_take_i | input | 1 | Read is a clearing read |
| rd_data_o | output | DW | Contents of the selected register |
| vld_o | output | NREG | Valid flag per register |
| full_o | output | NREG | Group full, flagged at its input stage |
| cfg_err_o | output | NREG | Illegal field on a non-input stage |

## Verification
The properties assume that the control words only change while reset is held, because the group boundaries they derive must hold across the cycle they compare. The stimulus applies a new random or directed configuration only inside a reset pulse. It then mixes writes, clearing reads of output stages and stray clearing reads of inner stages, which exercises overwrite, refusal and simultaneous read-write on groups of every depth.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
    localparam int CW       = 16;
    localparam int RLD_LSB  = 0;
    localparam int RLD_W    = 2;
    localparam int LINK_BIT = 5;
    localparam int HOLD_BIT = 6;

    typedef struct packed {
        logic             hold;
        logic             link;
        logic [RLD_W-1:0] rld;
    } ctl_t;

    function automatic ctl_t ctl_decode(input logic [CW-1:0] w);
        ctl_t c;
        c.hold = w[HOLD_BIT];
        c.link = w[LINK_BIT];
        c.rld  = w[RLD_LSB +: RLD_W];
        return c;
    endfunction
endpackage

// File: rtl/rcf_link_decode.sv
module rcf_link_decode
    import rcf_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0][CW-1:0] ctrl_i,
    output logic [NREG-1:0]         is_out_o,
    output logic [NREG-1:0]         is_head_o,
    output logic [NREG-1:0][IW-1:0] out_idx_o,
    output logic [NREG-1:0][IW-1:0] head_idx_o,
    output logic [NREG-1:0]         hold_o,
    output logic [NREG-1:0]         cfg_err_o
);
    ctl_t [NREG-1:0] ctl;
    logic            unused_ctrl_bits;

    assign unused_ctrl_bits = ^ctrl_i;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign ctl[g] = ctl_decode(ctrl_i[g]);
        if (g == NREG - 1) begin : g_top
            assign is_head_o[g] = 1'b1;
        end else begin : g_mid
            assign is_head_o[g] = !ctl[g].link;
        end
        if (g == 0) begin : g_bot
            assign is_out_o[g] = 1'b1;
        end else begin : g_up
            assign is_out_o[g] = !ctl[g-1].link;
        end
        assign hold_o[g]    = ctl[g].hold && is_head_o[g];
        assign cfg_err_o[g] = !is_head_o[g] && (ctl[g].hold || (ctl[g].rld != '0));
    end

    always_comb begin
        logic [IW-1:0] run_lo;
        logic [IW-1:0] run_hi;
        run_lo = '0;
        for (int i = 0; i < NREG; i++) begin
            if (is_out_o[i]) run_lo = IW'(i);
            out_idx_o[i] = run_lo;
        end
        run_hi = IW'(NREG - 1);
        for (int i = NREG - 1; i >= 0; i--) begin
            if (is_head_o[i]) run_hi = IW'(i);
            head_idx_o[i] = run_hi;
        end
    end
endmodule

// File: rtl/rcf_free_scan.sv
module rcf_free_scan #(
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] vld_i,
    input  logic [NREG-1:0] member_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < NREG; i++) begin
            if (member_i[i] && !vld_i[i] && !found_o) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/res_chain_fifo.sv
module res_chain_fifo
    import rcf_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 14,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREG-1:0][CW-1:0] ctrl_i,
    input  logic                    res_valid_i,
    input  logic [IW-1:0]           res_sel_i,
    input  logic [DW-1:0]           res_data_i,
    output logic                    res_ready_o,
    input  logic [IW-1:0]           rd_sel_i,
    input  logic                    rd_take_i,
    output logic [DW-1:0]           rd_data_o,
    output logic [NREG-1:0]         vld_o,
    output logic [NREG-1:0]         full_o,
    output logic [NREG-1:0]         cfg_err_o
);
    typedef struct packed {
        logic [NREG-1:0]         vld;
        logic [NREG-1:0][DW-1:0] dat;
    } bank_t;

    bank_t st_q, st_d;

    logic [NREG-1:0]         is_out, is_head, hold;
    logic [NREG-1:0][IW-1:0] out_idx, head_idx;

    logic                    take_ok;
    logic [NREG-1:0]         shf_vld, up_vld, wr_mem;
    logic [NREG-1:0][DW-1:0] shf_dat, up_dat;
    logic [IW-1:0]           wr_head, wr_tgt, slot_idx;
    logic                    slot_found;

    rcf_link_decode #(.NREG(NREG)) u_links (
        .ctrl_i     (ctrl_i),
        .is_out_o   (is_out),
        .is_head_o  (is_head),
        .out_idx_o  (out_idx),
        .head_idx_o (head_idx),
        .hold_o     (hold),
        .cfg_err_o  (cfg_err_o)
    );

    // Clearing read of an output stage shifts its group down by one.
    always_comb begin
        take_ok = rd_take_i && is_out[rd_sel_i];
        up_vld  = {1'b0, st_q.vld[NREG-1:1]};
        up_dat  = {{DW{1'b0}}, st_q.dat[NREG-1:1]};
        shf_vld = st_q.vld;
        shf_dat = st_q.dat;
        for (int i = 0; i < NREG; i++) begin
            if (take_ok && (out_idx[i] == rd_sel_i)) begin
                shf_vld[i] = is_head[i] ? 1'b0 : up_vld[i];
                shf_dat[i] = up_dat[i];
            end
        end
        for (int i = 0; i < NREG; i++) begin
            wr_mem[i] = (out_idx[i] == out_idx[res_sel_i]);
        end
        wr_head = head_idx[res_sel_i];
    end

    rcf_free_scan #(.NREG(NREG)) u_scan (
        .vld_i    (shf_vld),
        .member_i (wr_mem),
        .found_o  (slot_found),
        .idx_o    (slot_idx)
    );

    assign res_ready_o = !(hold[wr_head] && !slot_found);

    always_comb begin
        st_d     = st_q;
        st_d.vld = shf_vld;
        st_d.dat = shf_dat;
        wr_tgt   = slot_found ? slot_idx : wr_head;
        if (res_valid_i && res_ready_o) begin
            st_d.vld[wr_tgt] = 1'b1;
            st_d.dat[wr_tgt] = res_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        logic run;
        run = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            run       = st_q.vld[i] && (is_out[i] || run);
            full_o[i] = is_head[i] && run;
        end
    end

    assign vld_o     = st_q.vld;
    assign rd_data_o = st_q.dat[rd_sel_i];
endmodule

// File: rtl/res_chain_fifo_chk.sv
module res_chain_fifo_chk
    import rcf_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NREG-1:0][CW-1:0] ctrl_i,
    input logic                    res_valid_i,
    input logic [IW-1:0]           res_sel_i,
    input logic [IW-1:0]           rd_sel_i,
    input logic                    rd_take_i,
    input logic                    res_ready_o,
    input logic [NREG-1:0]         vld_o,
    input logic [NREG-1:0]         full_o
);
    logic [NREG-1:0] heads;
    logic [IW-1:0]   sel_head;
    logic            rd_is_out;

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            heads[i] = (i == NREG - 1) || !ctrl_i[i][LINK_BIT];
        end
        sel_head = IW'(NREG - 1);
        for (int i = NREG - 1; i >= 0; i--) begin
            if (i >= int'(res_sel_i) && heads[i]) sel_head = IW'(i);
        end
        rd_is_out = 1'b1;
        for (int i = 0; i < NREG; i++) begin
            if (i + 1 == int'(rd_sel_i) && ctrl_i[i][LINK_BIT]) rd_is_out = 1'b0;
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> (vld_o == '0 && full_o == '0)); // R3

    AST_FULL_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o & ~heads) == '0); // R10

    AST_READY_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i[sel_head][HOLD_BIT] |-> res_ready_o); // R7

    AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && !res_ready_o && !rd_take_i) |=> $stable(vld_o)); // R8

    AST_INNER_TAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take_i && !rd_is_out && !res_valid_i) |=> $stable(vld_o)); // R6

    AST_TAKE_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take_i && rd_is_out && vld_o[rd_sel_i] && !res_valid_i)
        |=> ($countones(vld_o) + 1 == $countones($past(vld_o)))); // R5

    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take_i |=> ($countones(vld_o) >= $countones($past(vld_o))
                        && $countones(vld_o) <= $countones($past(vld_o)) + 1)); // R4
endmodule

bind res_chain_fifo res_chain_fifo_chk #(.NREG(NREG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl_i),
    .res_valid_i (res_valid_i),
    .res_sel_i   (res_sel_i),
    .rd_sel_i    (rd_sel_i),
    .rd_take_i   (rd_take_i),
    .res_ready_o (res_ready_o),
    .vld_o       (vld_o),
    .full_o      (full_o)
);

// File: tb/res_chain_fifo_test.sv
module res_chain_fifo_test;
    localparam int CLK_PERIOD = 40;
    localparam int NREG = 8;
    localparam int DW   = 14;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NREG-1:0][15:0] ctrl = '0;
    logic                  res_valid_i = 1'b0;
    logic [2:0]            res_sel_i = '0;
    logic [DW-1:0]         res_data_i = '0;
    logic                  res_ready_o;
    logic [2:0]            rd_sel_i = '0;
    logic                  rd_take_i = 1'b0;
    logic [DW-1:0]         rd_data_o;
    logic [NREG-1:0]       vld_o, full_o, cfg_err_o;

    int nchk = 0;
    int nfail = 0;
    bit            mv [NREG];
    logic [DW-1:0] md [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    res_chain_fifo #(.NREG(NREG), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl),
        .res_valid_i(res_valid_i), .res_sel_i(res_sel_i), .res_data_i(res_data_i),
        .res_ready_o(res_ready_o), .rd_sel_i(rd_sel_i), .rd_take_i(rd_take_i),
        .rd_data_o(rd_data_o), .vld_o(vld_o), .full_o(full_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int f_out(input int i);
        int j = i;
        while (j > 0 && ctrl[j-1][5]) j--;
        return j;
    endfunction

    function automatic int f_head(input int i);
        int j = i;
        while (j < NREG - 1 && ctrl[j][5]) j++;
        return j;
    endfunction

    function automatic logic [NREG-1:0] exp_cfg_err();
        logic [NREG-1:0] e;
        for (int i = 0; i < NREG; i++)
            e[i] = (i < NREG - 1) && ctrl[i][5] && (ctrl[i][6] || ctrl[i][1:0] != 2'b00);
        return e;
    endfunction

    task automatic check_state(input string tag);
        logic [NREG-1:0] ev, ef;
        bit all;
        for (int i = 0; i < NREG; i++) begin
            ev[i] = mv[i];
            all = 1'b1;
            for (int j = f_out(i); j <= i; j++) all &= mv[j];
            ef[i] = (f_head(i) == i) && all;
        end
        chk(vld_o === ev, tag, "valid flags", 32'(vld_o), 32'(ev));
        chk(full_o === ef, "R10", "full flags", 32'(full_o), 32'(ef));
        for (int i = 0; i < NREG; i++) begin
            rd_sel_i = 3'(i);
            #1;
            if (mv[i]) chk(rd_data_o === md[i], tag, $sformatf("data reg %0d", i),
                           32'(rd_data_o), 32'(md[i]));
        end
    endtask

    task automatic do_reset(input logic [NREG-1:0][15:0] cfg);
        @(negedge clk);
        rst_n = 1'b0;
        ctrl  = cfg;
        res_valid_i = 1'b0;
        rd_take_i   = 1'b0;
        for (int i = 0; i < NREG; i++) begin mv[i] = 1'b0; md[i] = '0; end
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(vld_o === '0, "R3", "valid after reset", 32'(vld_o), 0);
        chk(full_o === '0, "R3", "full after reset", 32'(full_o), 0);
        chk(res_ready_o === 1'b1, "R3", "ready after reset", 32'(res_ready_o), 1);
        chk(cfg_err_o === exp_cfg_err(), "R2", "config error flags",
            32'(cfg_err_o), 32'(exp_cfg_err()));
    endtask

    task automatic cycle(input bit v, input int sel, input logic [DW-1:0] d,
                         input bit take, input int rsel, input string tg);
        bit            sv [NREG];
        logic [DW-1:0] sd [NREG];
        int o, h, wo, wh, tgt;
        bit fnd, rdy, shifted;
        string t;
        @(negedge clk);
        res_valid_i = v; res_sel_i = 3'(sel); res_data_i = d;
        rd_take_i = take; rd_sel_i = 3'(rsel);
        for (int i = 0; i < NREG; i++) begin sv[i] = mv[i]; sd[i] = md[i]; end
        o = f_out(rsel); h = f_head(rsel);
        shifted = take && (o == rsel);
        if (shifted) begin
            for (int j = o; j < h; j++) begin sv[j] = sv[j+1]; sd[j] = sd[j+1]; end
            sv[h] = 1'b0;
        end
        wo = f_out(sel); wh = f_head(sel);
        fnd = 1'b0; tgt = wh;
        for (int j = wh; j >= wo; j--) if (!sv[j]) begin fnd = 1'b1; tgt = j; end
        rdy = !(ctrl[wh][6] && !fnd);
        if (tg != "") t = tg;
        else if (shifted && v) t = "R9";
        else if (shifted) t = "R5";
        else if (take) t = "R6";
        else if (v && !rdy) t = "R8";
        else if (v && !fnd) t = "R7";
        else if (v) t = "R4";
        else t = "R11";
        #1;
        chk(res_ready_o === rdy, rdy ? t : "R8", "ready", 32'(res_ready_o), 32'(rdy));
        if (v && rdy) begin sv[tgt] = 1'b1; sd[tgt] = d; end
        @(posedge clk);
        #1;
        res_valid_i = 1'b0;
        rd_take_i   = 1'b0;
        for (int i = 0; i < NREG; i++) begin mv[i] = sv[i]; md[i] = sd[i]; end
        check_state(t);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [NREG-1:0][15:0] cfg;
        void'($urandom(32'h5eed_0042));

        // Group 0..3 without hold, group 4..5 with hold, singles 6 and 7 (7 holds)
        cfg = '0;
        cfg[0] = 16'h0020; cfg[1] = 16'h0020; cfg[2] = 16'h0020; cfg[3] = 16'h0000;
        cfg[4] = 16'h0020; cfg[5] = 16'h0040; cfg[6] = 16'h0000; cfg[7] = 16'h0040;
        do_reset(cfg);
        cycle(1, 1, 14'h100, 0, 0, "R1");   // aimed at an inner member, lands in reg 0
        cycle(1, 3, 14'h101, 0, 0, "R4");
        cycle(1, 3, 14'h102, 0, 0, "R4");
        cycle(1, 3, 14'h103, 0, 0, "R10");
        cycle(1, 3, 14'h3ff, 0, 0, "R7");   // full: only reg 3 replaced
        cycle(0, 0, 14'h000, 1, 2, "R6");   // clearing read of intermediate ignored
        cycle(0, 0, 14'h000, 1, 3, "R6");   // clearing read of input stage ignored
        cycle(0, 0, 14'h000, 1, 0, "R5");
        cycle(1, 5, 14'h200, 0, 0, "R4");
        cycle(1, 4, 14'h201, 0, 0, "R4");
        cycle(1, 5, 14'h202, 0, 0, "R8");   // held group full: refused
        cycle(1, 5, 14'h203, 1, 4, "R9");   // read frees a stage in the same cycle
        cycle(1, 7, 14'h005, 0, 0, "R4");
        cycle(1, 7, 14'h006, 0, 0, "R8");
        cycle(0, 0, 14'h000, 0, 1, "R11");  // plain read changes nothing
        cycle(0, 0, 14'h000, 1, 7, "R5");

        // Link bit wrongly set on reg 1 merges groups 0..1 and 2..3
        cfg = '0;
        cfg[0] = 16'h0020; cfg[1] = 16'h0020; cfg[2] = 16'h0020; cfg[3] = 16'h0000;
        do_reset(cfg);
        cycle(1, 3, 14'h055, 0, 0, "R12");
        chk(vld_o[0] === 1'b1, "R12", "merged group output", 32'(vld_o[0]), 1);

        // Illegal fields on linked stages
        cfg = '0;
        cfg[0] = 16'h0061; cfg[2] = 16'h0002; cfg[3] = 16'h0022; cfg[7] = 16'h0060;
        do_reset(cfg);
        chk(cfg_err_o === 8'b0000_1001, "R2", "directed config errors", 32'(cfg_err_o), 32'h09);

        // Random configurations and traffic
        for (int p = 0; p < 24; p++) begin
            for (int i = 0; i < NREG; i++) begin
                cfg[i] = '0;
                cfg[i][5] = ($urandom % 3) != 0;
                if (!cfg[i][5] || ($urandom % 8) == 0) begin
                    cfg[i][6]   = $urandom % 2;
                    cfg[i][1:0] = 2'($urandom % 4);
                end
            end
            do_reset(cfg);
            for (int k = 0; k < 250; k++) begin
                int rs;
                rs = $urandom % NREG;
                if (($urandom % 10) < 7) rs = f_out(rs);
                cycle(($urandom % 3) != 0, $urandom % NREG, 14'($urandom),
                      ($urandom % 3) == 0, rs, "");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule